// File: doc/BRIEF.md
# Three-Channel Compare Timer Bank

The block holds three 32-bit timers behind one word-addressed register port. Each timer has a live count, a reload value and two compare values. It counts up or down, either on every clock or only on a one-cycle strobe from an external tick input. When a timer rolls past its end value it takes its reload value and flags a wrap. Whenever a step lands the count on one of its compare values it flags a hit. The nine event flags sit in one shared sticky status word, and software clears a flag by writing a one to it. A shared mask word and a per-timer wrap-interrupt enable decide which flags reach the interrupt line of each timer.

A periodic tick is set up by loading the reload and count with the all-ones value minus (P - 1) and counting up: this gives a wrap every P steps. A one-shot delay is set up by writing a compare value ahead of the running count.

Top module: `tri_timer_bank`

## Requirements
- R1: After reset, every register reads zero and all three interrupt outputs are low.
- R2: The register map for timer n (n = 0, 1, 2) places the count at 0x10*n, the reload at 0x10*n+0x4, compare A at 0x10*n+0x8 and compare B at 0x10*n+0xC. Control is at 0x30, status at 0x34 and mask at 0x38. The reload, compare, control, mask and count registers read back what was written. Any other address reads zero.
- R3: Control bit 3n enables timer n. When control bit 3n+1 is clear, an enabled timer steps once per clock. Control bit 9+n set selects counting up, and clear selects counting down.
- R4: When control bit 3n+1 is set, timer n steps only in cycles where ext_tick is high. In every other cycle its count holds.
- R5: An up-counting timer at 0xFFFFFFFF loads its reload value on its next step and sets status bit 3n+2. With a reload value of 0xFFFFFFFF-(P-1), a wrap occurs every P steps.
- R6: A down-counting timer at zero loads its reload value on its next step and sets status bit 3n+2.
- R7: A step that makes the count equal to compare A sets status bit 3n. A step that makes it equal to compare B sets status bit 3n+1.
- R8: A timer whose enable bit is clear keeps its count unchanged.
- R9: Status bits are sticky. Each one-bit in a write to 0x34 clears that status bit. An event in the same cycle wins over the clear.
- R10: irq[n] is high when status bit 3n or 3n+1 is set with its mask bit clear, or when status bit 3n+2 is set with its mask bit clear and control bit 3n+2 set.
- R11: A write to a count register takes effect on the next clock edge, even while the timer runs. In that cycle the write replaces the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | One-cycle step strobe for timers in tick mode |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | AW (6) | Byte address, word aligned |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data for bus_addr, combinational |
| irq | output | 3 | One interrupt per timer |

## Verification
Several checks run on every clock edge. They cover these properties: the count holds while a timer is disabled or waiting for a tick, the roll-over value equals the reload in both directions, a written count lands on the next edge, and a hit leaves its status bit set. Also checked on every edge are that a write-one clear removes a flag unless an event set it again, and that a fully masked timer keeps its interrupt low. Other behaviour can be shown only by the bench's scenarios. This covers the exact number of steps in a free-running window, the address decode and read-back, the order in which hits and wraps appear during a countdown, and how the mask and wrap enable combine on the interrupt lines.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NT       = 3;  // timers in the bank
  localparam int unsigned SRC_PER  = 3;  // event sources per timer
  localparam int unsigned DIR_BASE = 9;  // first direction bit in control

  // word select inside a timer group
  typedef enum logic [1:0] {RS_COUNT, RS_RELOAD, RS_CMPA, RS_CMPB} tmr_rsel_e;
  // word select inside the shared group
  typedef enum logic [1:0] {SH_CTRL, SH_STAT, SH_MASK, SH_NONE} tmr_shsel_e;
  localparam logic [1:0] GRP_SHARED = 2'd3;

  function automatic int unsigned en_bit(input int unsigned n);
    return SRC_PER * n;
  endfunction
  function automatic int unsigned tick_bit(input int unsigned n);
    return SRC_PER * n + 1;
  endfunction
  function automatic int unsigned wrap_ie_bit(input int unsigned n);
    return SRC_PER * n + 2;
  endfunction
  function automatic int unsigned dir_bit(input int unsigned n);
    return DIR_BASE + n;
  endfunction
endpackage

// File: rtl/tmr_lane.sv
module tmr_lane #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          use_tick,
  input  logic          tick,
  input  logic          up,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  output logic [CW-1:0] count,
  output logic          ev_hit_a,
  output logic          ev_hit_b,
  output logic          ev_wrap
);
  localparam logic [CW-1:0] TOP = '1;

  // {wrap, next value} for one step from cur
  function automatic logic [CW:0] advance(input logic [CW-1:0] cur,
                                          input logic dir_up,
                                          input logic [CW-1:0] rld);
    if (dir_up)
      return (cur == TOP) ? {1'b1, rld} : {1'b0, cur + 1'b1};
    else
      return (cur == '0) ? {1'b1, rld} : {1'b0, cur - 1'b1};
  endfunction

  logic [CW-1:0] cnt_q, nxt;
  logic          wrap_n, step;

  assign step = en & (use_tick ? tick : 1'b1) & ~cnt_wr;
  always_comb {wrap_n, nxt} = advance(cnt_q, up, reload);

  assign ev_wrap  = step & wrap_n;
  assign ev_hit_a = step & (nxt == cmp_a);
  assign ev_hit_b = step & (nxt == cmp_b);
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= cnt_wdata;
    else if (step)   cnt_q <= nxt;
  end

  // R8
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(count));
  // R4
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_tick && !tick && !cnt_wr) |=> $stable(count));
  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && (!use_tick || tick) && !cnt_wr && count == TOP) |=> (count == $past(reload)));
  // R6
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && (!use_tick || tick) && !cnt_wr && count == '0) |=> (count == $past(reload)));
  // R11
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(cnt_wdata)));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] flags,   // {wrap, hit B, hit A}
  input  logic [2:0] masked,
  input  logic       wrap_ie,
  output logic       irq
);
  assign irq = |(flags & ~masked & {wrap_ie, 2'b11});

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&masked) |-> !irq);
endmodule

// File: rtl/tri_timer_bank.sv
module tri_timer_bank
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 32,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [NT-1:0] irq
);
  localparam int unsigned NSRC   = NT * SRC_PER;
  localparam int unsigned CTRL_W = DIR_BASE + NT;

  logic [1:0] grp, rsel;
  logic       addr_ok, wr_shared;
  assign grp       = bus_addr[5:4];
  assign rsel      = bus_addr[3:2];
  assign addr_ok   = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 6) == '0);
  assign wr_shared = bus_wr & addr_ok & (grp == GRP_SHARED);

  logic [CTRL_W-1:0]       ctrl_q;
  logic [NSRC-1:0]         st_q, msk_q, ev_set, st_clr;
  logic [NT-1:0][CW-1:0]   cnt_v, rld_q, ca_q, cb_q;

  for (genvar n = 0; n < NT; n++) begin : g_tmr
    logic wr_here, hit_a, hit_b, wrap;
    assign wr_here = bus_wr & addr_ok & (grp == 2'(n));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rld_q[n] <= '0;
        ca_q[n]  <= '0;
        cb_q[n]  <= '0;
      end else if (wr_here) begin
        if (rsel == RS_RELOAD) rld_q[n] <= bus_wdata;
        if (rsel == RS_CMPA)   ca_q[n]  <= bus_wdata;
        if (rsel == RS_CMPB)   cb_q[n]  <= bus_wdata;
      end
    end

    tmr_lane #(.CW(CW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q[en_bit(n)]),
      .use_tick (ctrl_q[tick_bit(n)]),
      .tick     (ext_tick),
      .up       (ctrl_q[dir_bit(n)]),
      .cnt_wr   (wr_here && rsel == RS_COUNT),
      .cnt_wdata(bus_wdata),
      .reload   (rld_q[n]),
      .cmp_a    (ca_q[n]),
      .cmp_b    (cb_q[n]),
      .count    (cnt_v[n]),
      .ev_hit_a (hit_a),
      .ev_hit_b (hit_b),
      .ev_wrap  (wrap)
    );

    assign ev_set[SRC_PER*n +: SRC_PER] = {wrap, hit_b, hit_a};

    tmr_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags  (st_q[SRC_PER*n +: SRC_PER]),
      .masked (msk_q[SRC_PER*n +: SRC_PER]),
      .wrap_ie(ctrl_q[wrap_ie_bit(n)]),
      .irq    (irq[n])
    );

    // R7
    hit_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_a |=> st_q[SRC_PER*n]);
    // R7
    hit_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_b |=> st_q[SRC_PER*n+1]);
  end

  assign st_clr = (wr_shared && rsel == SH_STAT) ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      msk_q  <= '0;
      st_q   <= '0;
    end else begin
      if (wr_shared && rsel == SH_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_shared && rsel == SH_MASK) msk_q  <= bus_wdata[NSRC-1:0];
      st_q <= (st_q & ~st_clr) | ev_set;
    end
  end

  for (genvar b = 0; b < NSRC; b++) begin : g_stat_chk
    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr[b] && !ev_set[b]) |=> !st_q[b]);
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      if (grp == GRP_SHARED) begin
        case (rsel)
          SH_CTRL: bus_rdata = CW'(ctrl_q);
          SH_STAT: bus_rdata = CW'(st_q);
          SH_MASK: bus_rdata = CW'(msk_q);
          default: bus_rdata = '0;
        endcase
      end else begin
        for (int n = 0; n < NT; n++) begin
          if (grp == 2'(n)) begin
            case (rsel)
              RS_COUNT:  bus_rdata = cnt_v[n];
              RS_RELOAD: bus_rdata = rld_q[n];
              RS_CMPA:   bus_rdata = ca_q[n];
              default:   bus_rdata = cb_q[n];
            endcase
          end
        end
      end
    end
  end
endmodule

// File: tb/tri_timer_bank_bench.sv
`timescale 1ns/1ps
module tri_timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  always #2.5 clk = ~clk;

  tri_timer_bank u_tri_timer_bank (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // monitor: compares the oldest expected item away from the active edge
  always @(negedge clk) begin
    sb_item_t it;
    logic [31:0] act;
    if (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = it.is_irq ? {29'd0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {29'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic tick();
    @(posedge clk); #1; ext_tick = 1'b1;
    @(posedge clk); #1; ext_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3); #1; rst_n = 1'b1;

    // R1 reset state
    rd(6'h30, 32'h0, "R1 control");
    rd(6'h34, 32'h0, "R1 status");
    rd(6'h38, 32'h0, "R1 mask");
    rd(6'h00, 32'h0, "R1 count0");
    rd(6'h24, 32'h0, "R1 reload2");
    chk_irq(3'b000, "R1 irq");

    // R2 map and read-back
    wr(6'h14, 32'h1111_1111);
    wr(6'h18, 32'h2222_2222);
    wr(6'h2C, 32'h3333_3333);
    wr(6'h38, 32'h1FF);
    rd(6'h14, 32'h1111_1111, "R2 reload1");
    rd(6'h18, 32'h2222_2222, "R2 cmpA1");
    rd(6'h2C, 32'h3333_3333, "R2 cmpB2");
    rd(6'h38, 32'h1FF, "R2 mask");
    rd(6'h3C, 32'h0, "R2 unmapped");
    wr(6'h38, 32'h0);

    // R3 free run up: 7 steps
    wr(6'h00, 32'd100);
    wr(6'h30, 32'h201);
    idle(5);
    wr(6'h30, 32'h0);
    rd(6'h00, 32'd107, "R3 up free run");
    // R3 free run down
    wr(6'h00, 32'd50);
    wr(6'h30, 32'h001);
    idle(5);
    wr(6'h30, 32'h0);
    rd(6'h00, 32'd43, "R3 down free run");
    // R8 disabled holds
    idle(10);
    rd(6'h00, 32'd43, "R8 frozen");

    // R4, R6, R7 timer1 down in tick mode
    wr(6'h18, 32'd1);
    wr(6'h1C, 32'd0);
    wr(6'h10, 32'd3);
    wr(6'h30, 32'h038);
    idle(10);
    rd(6'h10, 32'd3, "R4 no tick no step");
    tick();
    rd(6'h10, 32'd2, "R4 one tick");
    rd(6'h34, 32'h0, "R7 no hit yet");
    tick();
    rd(6'h34, 32'h08, "R7 hit A");
    chk_irq(3'b010, "R10 hit A irq");
    tick();
    rd(6'h34, 32'h18, "R7 hit B");
    tick();
    rd(6'h10, 32'h1111_1111, "R6 down reload");
    rd(6'h34, 32'h38, "R6 wrap flag");

    // R10 gating
    wr(6'h38, 32'h18);
    chk_irq(3'b010, "R10 wrap with enable");
    wr(6'h30, 32'h018);
    chk_irq(3'b000, "R10 wrap enable off");
    wr(6'h30, 32'h038);
    wr(6'h38, 32'h38);
    chk_irq(3'b000, "R10 all masked");

    // R9 write-one clear
    wr(6'h34, 32'h08);
    rd(6'h34, 32'h30, "R9 partial clear");
    wr(6'h34, 32'h30);
    rd(6'h34, 32'h0, "R9 full clear");
    wr(6'h38, 32'h0);

    // R5 timer2 up, period 3
    wr(6'h24, 32'hFFFF_FFFD);
    wr(6'h20, 32'hFFFF_FFFD);
    wr(6'h30, 32'h9C0);
    tick(); tick();
    rd(6'h20, 32'hFFFF_FFFF, "R5 at top");
    rd(6'h34, 32'h0, "R5 no wrap yet");
    tick();
    rd(6'h20, 32'hFFFF_FFFD, "R5 reloaded");
    rd(6'h34, 32'h100, "R5 wrap flag");
    chk_irq(3'b100, "R10 wrap irq timer2");

    // R11 count write while running
    wr(6'h30, 32'h840);
    wr(6'h20, 32'd5);
    wr(6'h30, 32'h0);
    rd(6'h20, 32'd7, "R11 write wins then steps");

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule